// File: doc/BRIEF.md
# Serial Port with Receive and Transmit FIFOs

This block is a processor-bus serial port. Software programs a frame format and a 12-bit bit-rate divisor, then writes characters into an eight-entry transmit queue. The block serialises them onto `txd` with an oversampling tick that runs sixteen times per bit. The receiver watches `rxd`, finds the middle of each bit, and stores each character in an eight-entry receive queue. Three error flags travel with each stored character.

Software reads status register B before each data read. Its error bits describe the character that the next data read will pop. Status register A carries two level service requests and three sticky events: receiver idle, break start and break end. A write of 1 clears each sticky event. An interrupt line combines the requests with their enable bits. A control bit forces the line to the spacing level, which sends a break.

Top module: `uart_fifo_port`

## Requirements
- R1: After reset `txd` is high and `irq` is low. The frame register reads 0x08, and the divisor and control register read 0. Status A (address 4) reads 0x01 and status B (address 5) reads 0x04.
- R2: The divisor N has N[11:8] in address 1 bits [3:0] and N[7:0] in address 2. Every serial bit lasts exactly 16*(N+1) clock cycles.
- R3: The frame register is at address 0. Bit 3 selects eight data bits (0 gives seven), bit 2 selects two stop bits, bit 0 enables parity and bit 1 selects odd parity (0 gives even). A frame is a low start bit, then the data LSB first, then the optional parity bit, then high stop bits. The line is high when idle.
- R4: A write to address 6 queues one character for transmission. The receiver samples each bit at its centre and stores the character. A read of address 6 with `bus_rd` returns the oldest character and removes it. A seven-bit character reads with bit 7 zero.
- R5: Status B bit 0 is transmitter busy, bit 1 is receive queue not empty and bit 2 is transmit queue not full. Bits 3, 4 and 5 are the parity, framing and overrun flags of the oldest received character. The parity flag is set when the received parity bit does not match the selected parity.
- R6: The framing flag is set on a character whose first stop bit is sampled low.
- R7: A character that arrives while the receive queue holds 8 entries is dropped. The overrun flag is then set on the newest stored entry and on no other.
- R8: The control register is at address 3. Bit 0 enables the receiver, bit 1 the transmitter, bit 2 the receive interrupt and bit 3 the transmit interrupt. While bit 4 is set, `txd` is held low.
- R9: Transmitter busy stays set until the last stop bit of the last queued character has ended, even while the transmit queue is not full.
- R10: Status A bit 0 (transmit request) is set while the transmit queue holds 4 or fewer entries. Bit 1 (receive request) is set while the receive queue holds 4 or more. `irq` is (control bit 2 AND (receive request OR any sticky event)) OR (control bit 3 AND transmit request).
- R11: Status A bit 2 sets when the receive queue holds data and no start bit has been seen for 3 character times. Writing 1 to it clears it.
- R12: A frame whose data, parity and first stop bit are all low sets status A bit 3 and is not stored. Status A bit 4 sets when the line then returns high. Writing 1 to either bit clears it.
- R13: With the transmitter disabled, no character leaves the queue and `txd` stays high. With the receiver disabled, no start bit is recognised and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive queue at address 6 |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that `rxd` moves only at frame-bit boundaries with whole frames, or that it is looped back from `txd`. It also assumes that software changes the frame format only between characters, and that the queue depth is a power of two. The stimulus keeps to these assumptions. It either loops `txd` into `rxd`, or drives whole frames from the bench at exactly sixteen clocks per bit with the divisor at zero. It changes the format only after the previous character has arrived.

// File: rtl/uart_fifo_port.sv
module uart_fifo_port #(
  parameter int DEPTH = 8,
  parameter int DIVW = 12,
  parameter int IDLE_CHARS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  input  logic       rxd,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int IW = $clog2(IDLE_CHARS * 16 * 12 + 1);
  localparam logic [2:0] A_FMT = 3'd0, A_DIVH = 3'd1, A_DIVL = 3'd2, A_CTRL = 3'd3,
                         A_STA = 3'd4, A_STB = 3'd5, A_DATA = 3'd6;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_BRK} rx_state_t;

  logic [3:0] fmt;
  logic [DIVW-1:0] div;
  logic [4:0] ctrl;
  logic f_par, f_odd, f_two, f_eight;
  logic [3:0] nbits, rx_last;

  assign f_par   = fmt[0];
  assign f_odd   = fmt[1];
  assign f_two   = fmt[2];
  assign f_eight = fmt[3];
  assign nbits   = 4'd1 + (f_eight ? 4'd8 : 4'd7) + {3'b0, f_par} + (f_two ? 4'd2 : 4'd1);
  assign rx_last = (f_eight ? 4'd8 : 4'd7) + {3'b0, f_par} + 4'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fmt  <= 4'h8;
      div  <= '0;
      ctrl <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_FMT:  fmt <= bus_wdata[3:0];
        A_DIVH: div[DIVW-1:8] <= bus_wdata[DIVW-9:0];
        A_DIVL: div[7:0] <= bus_wdata;
        A_CTRL: ctrl <= bus_wdata[4:0];
        default: ;
      endcase
    end

  logic [DIVW-1:0] bcnt;
  logic tick;
  assign tick = (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else if (tick) bcnt <= div;
    else bcnt <= bcnt - DIVW'(1);

  logic [7:0] tx_mem [DEPTH];
  logic [CW-1:0] tx_wp, tx_rp, tx_cnt;
  logic tx_full, tx_push, tx_pop, tx_act, tx_busy;
  logic [11:0] tx_sh, tx_frame;
  logic [3:0] tx_left, tx_ph;
  logic [7:0] tx_head, tx_dm;

  assign tx_cnt  = tx_wp - tx_rp;
  assign tx_full = (tx_cnt == CW'(DEPTH));
  assign tx_push = bus_wr && bus_addr == A_DATA && !tx_full;
  assign tx_pop  = tick && !tx_act && ctrl[1] && tx_cnt != '0;
  assign tx_head = tx_mem[tx_rp[AW-1:0]];
  assign tx_dm   = f_eight ? tx_head : {1'b0, tx_head[6:0]};
  assign tx_busy = tx_act || tx_cnt != '0;

  always_comb begin
    tx_frame = '1;
    tx_frame[0] = 1'b0;
    if (f_eight) tx_frame[8:1] = tx_head;
    else tx_frame[7:1] = tx_head[6:0];
    if (f_par) tx_frame[f_eight ? 4'd9 : 4'd8] = ^tx_dm ^ f_odd;
  end

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp[AW-1:0]] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
      tx_act <= 1'b0;
      tx_sh <= '1;
      tx_left <= '0;
      tx_ph <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + CW'(1);
      if (tx_pop) begin
        tx_rp <= tx_rp + CW'(1);
        tx_act <= 1'b1;
        tx_sh <= tx_frame;
        tx_left <= nbits;
        tx_ph <= '0;
      end else if (tick && tx_act) begin
        tx_ph <= tx_ph + 4'd1;
        if (tx_ph == 4'd15) begin
          tx_sh <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) tx_act <= 1'b0;
        end
      end
    end

  assign txd = ctrl[4] ? 1'b0 : (tx_act ? tx_sh[0] : 1'b1);

  logic [1:0] rx_s;
  logic rxl;
  rx_state_t rx_st;
  logic [3:0] rx_ph, rx_idx;
  logic [9:1] rx_sh;
  logic [7:0] rx_data;
  logic rx_pbit, rx_perr, rx_zero;
  logic rx_wr, brk_b_p, brk_e_p;
  logic [10:0] rx_wdat;

  assign rxl     = rx_s[1];
  assign rx_data = f_eight ? rx_sh[8:1] : {1'b0, rx_sh[7:1]};
  assign rx_pbit = f_eight ? rx_sh[9] : rx_sh[8];
  assign rx_perr = f_par && ((^rx_data ^ f_odd) != rx_pbit);
  assign rx_zero = rx_data == 8'h00 && !(f_par && rx_pbit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s <= 2'b11;
      rx_st <= RX_IDLE;
      rx_ph <= '0;
      rx_idx <= '0;
      rx_sh <= '0;
      rx_wr <= 1'b0;
      rx_wdat <= '0;
      brk_b_p <= 1'b0;
      brk_e_p <= 1'b0;
    end else begin
      rx_s <= {rx_s[0], rxd};
      rx_wr <= 1'b0;
      brk_b_p <= 1'b0;
      brk_e_p <= 1'b0;
      if (tick) begin
        case (rx_st)
          RX_IDLE:
            if (ctrl[0] && !rxl) begin
              rx_st <= RX_START;
              rx_ph <= '0;
            end
          RX_START: begin
            rx_ph <= rx_ph + 4'd1;
            if (rx_ph == 4'd7) begin
              rx_ph <= '0;
              rx_idx <= 4'd1;
              rx_st <= rxl ? RX_IDLE : RX_BITS;
            end
          end
          RX_BITS: begin
            rx_ph <= rx_ph + 4'd1;
            if (rx_ph == 4'd15) begin
              rx_ph <= '0;
              rx_idx <= rx_idx + 4'd1;
              if (rx_idx != rx_last) rx_sh[rx_idx] <= rxl;
              else if (!rxl && rx_zero) begin
                brk_b_p <= 1'b1;
                rx_st <= RX_BRK;
              end else begin
                rx_wr <= 1'b1;
                rx_wdat <= {1'b0, !rxl, rx_perr, rx_data};
                rx_st <= RX_IDLE;
              end
            end
          end
          RX_BRK:
            if (rxl) begin
              brk_e_p <= 1'b1;
              rx_st <= RX_IDLE;
            end
          default: rx_st <= RX_IDLE;
        endcase
      end
    end

  logic [10:0] rx_mem [DEPTH];
  logic [CW-1:0] rx_wp, rx_rp, rx_cnt;
  logic [AW-1:0] rx_prev;
  logic rx_full, rx_ne, rx_pop;
  logic [10:0] rx_head;

  assign rx_cnt  = rx_wp - rx_rp;
  assign rx_full = (rx_cnt == CW'(DEPTH));
  assign rx_ne   = rx_cnt != '0;
  assign rx_pop  = bus_rd && bus_addr == A_DATA && rx_ne;
  assign rx_prev = rx_wp[AW-1:0] - AW'(1);
  assign rx_head = rx_mem[rx_rp[AW-1:0]];

  always_ff @(posedge clk)
    if (rx_wr) begin
      if (!rx_full) rx_mem[rx_wp[AW-1:0]] <= rx_wdat;
      else rx_mem[rx_prev][10] <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0;
      rx_rp <= '0;
    end else begin
      if (rx_wr && !rx_full) rx_wp <= rx_wp + CW'(1);
      if (rx_pop) rx_rp <= rx_rp + CW'(1);
    end

  logic idle_f, bb_f, be_f, tx_req, rx_req;
  logic [IW-1:0] idle_cnt, idle_lim;

  assign idle_lim = IW'(IDLE_CHARS * 16) * IW'(nbits);
  assign tx_req   = tx_cnt <= CW'(DEPTH / 2);
  assign rx_req   = rx_cnt >= CW'(DEPTH / 2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_cnt <= '0;
      idle_f <= 1'b0;
      bb_f <= 1'b0;
      be_f <= 1'b0;
    end else begin
      if (rx_st != RX_IDLE || !rx_ne) idle_cnt <= '0;
      else if (tick && idle_cnt != idle_lim) idle_cnt <= idle_cnt + IW'(1);
      if (bus_wr && bus_addr == A_STA) begin
        if (bus_wdata[2]) idle_f <= 1'b0;
        if (bus_wdata[3]) bb_f <= 1'b0;
        if (bus_wdata[4]) be_f <= 1'b0;
      end
      if (tick && rx_st == RX_IDLE && rx_ne && idle_cnt == idle_lim - IW'(1)) idle_f <= 1'b1;
      if (brk_b_p) bb_f <= 1'b1;
      if (brk_e_p) be_f <= 1'b1;
    end

  assign irq = (ctrl[2] && (rx_req || idle_f || bb_f || be_f)) || (ctrl[3] && tx_req);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FMT:  bus_rdata = {4'b0, fmt};
      A_DIVH: bus_rdata[DIVW-9:0] = div[DIVW-1:8];
      A_DIVL: bus_rdata = div[7:0];
      A_CTRL: bus_rdata = {3'b0, ctrl};
      A_STA:  bus_rdata = {3'b0, be_f, bb_f, idle_f, rx_req, tx_req};
      A_STB:  bus_rdata = {2'b0, rx_head[10:8] & {3{rx_ne}}, !tx_full, rx_ne, tx_busy};
      A_DATA: bus_rdata = rx_ne ? rx_head[7:0] : 8'h00;
      default: ;
    endcase
  end
endmodule

// File: rtl/uart_fifo_port_chk.sv
module uart_fifo_port_chk #(
  parameter int DEPTH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_act,
  input logic [11:0] tx_sh,
  input logic txe,
  input logic rie,
  input logic tie,
  input logic irq,
  input logic idle_f,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic [$clog2(DEPTH):0] rx_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tx_sh) && $stable(tx_act));

  // R13
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!txe && !tx_act) |=> !tx_act);

  // R7
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  // R4
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rie || tie));

  // R11
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_f) |-> rx_cnt != '0);
endmodule

bind uart_fifo_port uart_fifo_port_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_act(tx_act), .tx_sh(tx_sh),
  .txe(ctrl[1]), .rie(ctrl[2]), .tie(ctrl[3]), .irq(irq), .idle_f(idle_f),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_uart_fifo_port.sv
`timescale 1ns/1ps
module test_uart_fifo_port;
  localparam logic [2:0] A_FMT = 3'd0, A_DIVL = 3'd2, A_CTRL = 3'd3,
                         A_STA = 3'd4, A_STB = 3'd5, A_DATA = 3'd6;
  // {frame register nibble, character}
  localparam logic [11:0] VEC [8] = '{12'h855, 12'h9A3, 12'hF00, 12'h07F,
                                      12'h5C1, 12'h32A, 12'hBFF, 12'hD80};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic txd, rxd, irq;
  logic loop = 1'b1, tb_rx = 1'b1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign rxd = loop ? txd : tb_rx;
  always #2.5 clk = ~clk;

  uart_fifo_port i_uart_fifo_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_rx(output logic [7:0] s);
    s = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(A_STB, s);
      if (s[1]) break;
    end
  endtask

  task automatic wait_low();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!txd) break;
    end
  endtask

  task automatic send_raw(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tb_rx = bits[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk); tb_rx = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic drain();
    logic [7:0] s, d;
    for (int i = 0; i < 16; i++) begin
      rd(A_STB, s);
      if (s[1]) rd(A_DATA, d);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] s, d;
    logic [10:0] got;
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_STA, s); check("R1 status A", s, 8'h01);
    rd(A_STB, s); check("R1 status B", s, 8'h04);
    rd(A_FMT, s); check("R1 frame reg", s, 8'h08);
    check("R1 txd idle", txd, 1'b1);
    check("R1 irq", irq, 1'b0);

    wr(A_CTRL, 8'h03);
    wr(A_DIVL, 8'h00);

    // R4 / R3 loopback table over formats
    for (int v = 0; v < 8; v++) begin
      wr(A_FMT, {4'h0, VEC[v][11:8]});
      wr(A_DATA, VEC[v][7:0]);
      wait_rx(s);
      check("R4 R3 error bits", s[5:3], 3'b000);
      rd(A_DATA, d);
      check("R4 R3 character", d, VEC[v][7:0] & (VEC[v][11] ? 8'hFF : 8'h7F));
    end

    // R2 bit timing with N=2
    wr(A_FMT, 8'h08);
    wr(A_DIVL, 8'h02);
    wr(A_DATA, 8'h00);
    wait_low();
    cnt = 0;
    while (!txd && cnt < 2000) begin cnt++; @(negedge clk); end
    check("R2 nine low bits", cnt, 432);
    // R9 busy still set while stop bit leaves
    wait_rx(s);
    check("R9 busy during stop", s[0], 1'b1);
    repeat (200) @(negedge clk);
    rd(A_STB, s);
    check("R9 busy cleared", s[0], 1'b0);
    check("R9 not full", s[2], 1'b1);
    rd(A_DATA, d); check("R2 character", d, 8'h00);
    wr(A_DIVL, 8'h00);

    // R3 frame shape, 8E1 0x01
    wr(A_FMT, 8'h09);
    wr(A_DATA, 8'h01);
    wait_low();
    repeat (8) @(negedge clk);
    got = '0;
    for (int i = 0; i < 11; i++) begin got[i] = txd; repeat (16) @(negedge clk); end
    check("R3 line bits", got, {1'b1, 1'b1, 8'h01, 1'b0});
    wait_rx(s); rd(A_DATA, d);

    // R8 / R12 break send and detect
    wr(A_FMT, 8'h08);
    wr(A_STA, 8'hFF);
    wr(A_CTRL, 8'h13);
    repeat (400) @(negedge clk);
    check("R8 break line", txd, 1'b0);
    rd(A_STA, s); check("R12 break begin only", s[4:3], 2'b01);
    wr(A_CTRL, 8'h03);
    repeat (40) @(negedge clk);
    rd(A_STA, s); check("R12 break end", s[4:3], 2'b11);
    rd(A_STB, s); check("R12 break not stored", s[1], 1'b0);
    wr(A_STA, 8'h18);
    rd(A_STA, s); check("R12 cleared", s[4:3], 2'b00);

    // R5 parity error, R6 framing error
    loop = 1'b0;
    wr(A_FMT, 8'h09);
    send_raw({5'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    wait_rx(s); check("R5 parity flag", s[5:3], 3'b001);
    rd(A_DATA, d); check("R5 character", d, 8'h01);
    send_raw({5'b0, 1'b0, 1'b0, 8'h5A, 1'b0}, 11);
    wait_rx(s); check("R6 framing flag", s[5:3], 3'b010);
    rd(A_DATA, d); check("R6 character", d, 8'h5A);
    repeat (400) @(negedge clk);
    drain();

    // R7 overrun, R10 requests
    wr(A_FMT, 8'h08);
    wr(A_STA, 8'hFF);
    for (int k = 1; k <= 9; k++) send_raw({6'b0, 1'b1, 8'(k), 1'b0}, 10);
    check("R10 irq masked", irq, 1'b0);
    rd(A_STA, s); check("R10 rx request", s[1], 1'b1);
    wr(A_CTRL, 8'h07);
    check("R10 rx irq", irq, 1'b1);
    wr(A_CTRL, 8'h03);
    for (int j = 1; j <= 8; j++) begin
      rd(A_STB, s);
      check("R7 overrun position", s[5], j == 8);
      rd(A_DATA, d);
      check("R7 stored order", d, 8'(j));
    end
    rd(A_STB, s); check("R7 ninth dropped", s[1], 1'b0);
    wr(A_CTRL, 8'h0B);
    check("R10 tx irq", irq, 1'b1);
    wr(A_CTRL, 8'h03);
    check("R10 irq off", irq, 1'b0);

    // R11 idle detection
    loop = 1'b1;
    wr(A_STA, 8'hFF);
    wr(A_DATA, 8'h42);
    wait_rx(s);
    repeat (160) @(negedge clk);
    rd(A_STA, s); check("R11 not yet idle", s[2], 1'b0);
    repeat (400) @(negedge clk);
    rd(A_STA, s); check("R11 idle set", s[2], 1'b1);
    wr(A_STA, 8'h04);
    rd(A_STA, s); check("R11 idle cleared", s[2], 1'b0);
    rd(A_DATA, d); check("R11 character", d, 8'h42);

    // R13 enables
    wr(A_CTRL, 8'h01);
    wr(A_DATA, 8'h33);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!txd) cnt++; end
    check("R13 tx held", cnt, 0);
    rd(A_STB, s); check("R13 queued busy", s[1:0], 2'b01);
    wr(A_CTRL, 8'h02);
    repeat (300) @(negedge clk);
    rd(A_STB, s); check("R13 rx ignored", s[1:0], 2'b00);

    done = 1'b1;
    finish_run();
  end
endmodule